// File: doc/BRIEF.md
# Multi-Mode Event Counter

This block is a wide up/down counter with four counting disciplines: free-running, one-shot, clamped between zero and a limit, and wrapping modulo a limit. It takes one count strobe per step together with a direction level, plus an index strobe that has already been qualified upstream. A data register supplies the limit and the preload value. A hold register keeps a snapshot of the counter. A host port writes these registers and issues one command per cycle.

Four events are detected: an overflow step, an underflow step, the counter equalling the limit, and an index strobe. Each is recorded in a sticky status word. The status word feeds an active-low latched flag, which stays low until the host clears the status. A second active-low dynamic flag follows the selected event conditions cycle by cycle. Its selection is programmable only in free-running mode; in the other modes the count mode fixes it. A two-state run/stop machine makes the one-shot mode stop after its first overflow or underflow.

Top module: `evt_counter`

## Requirements
- R1: While rst_n is low, count_o, hold_o and status_o are zero and both flags are high. The data, mode-0 and mode-1 registers are also cleared.
- R2: In free-running mode (mode-0 bits [1:0] = 0), an up step from all-ones gives 0 and a down step from 0 gives all-ones. Any other step adds or subtracts 1.
- R3: In modulo mode (bits [1:0] = 3), an up step from a value at or above the limit L gives 0, and a down step from 0 gives L.
- R4: In clamped mode (bits [1:0] = 2), an up step at or above L leaves the counter unchanged, and so does a down step at 0.
- R5: The run/stop machine has states RUN and STOP. RUN goes to STOP when a one-shot-mode (bits [1:0] = 1) step overflows or underflows; that step still wraps as in R2. STOP ignores count strobes. STOP returns to RUN on a counter load, a counter clear or a mode-0 write.
- R6: host_cmd codes are 1 = load counter with L, 2 = clear counter, 3 = clear data register, 4 = copy counter to hold_o, 5 = clear status. host_addr 0/1/2 writes the data, mode-0 or mode-1 register. A clear beats a load, and both beat a step taken in the same cycle.
- R7: Mode-0 bits [3:2] set the index action: 0 none, 1 load L, 2 clear counter, 3 copy counter to hold_o.
- R8: Mode-0 bits [5:4] = k give a limit L equal to the data register masked to its low 32-8k bits.
- R9: status_o bits are carry [0], borrow [1], match [2] and index [3]. A bit is set by its event, and the match bit is set at the edge after the counter equals L. A bit then stays set until clear-status (command 5). An event in the same cycle as the clear wins.
- R10: flag_latched_n is low exactly when a status bit enabled by mode-1 bits [3:0] (same bit order) is set.
- R11: flag_dyn_n is low while the chosen condition holds. The conditions are the one-cycle carry, borrow and index pulses that follow an event, and the match level. Free-running mode chooses by mode-1. One-shot mode chooses carry or borrow. Clamped and modulo modes choose match with the last step up, or borrow.
- R12: A count strobe with count_enable low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_strobe | input | 1 | One count step request |
| cnt_up | input | 1 | Step direction, 1 = up |
| count_enable | input | 1 | Gates count strobes |
| idx_strobe | input | 1 | Qualified index pulse |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register select for writes |
| host_wdata | input | W | Write data |
| host_cmd | input | 3 | Command code, 0 = none |
| count_o | output | W | Counter value |
| hold_o | output | W | Snapshot register |
| status_o | output | 4 | Sticky event bits |
| flag_latched_n | output | 1 | Latched event flag, active low |
| flag_dyn_n | output | 1 | Dynamic event flag, active low |

## Verification
The bench builds the block with its default width of 32. Every limit window from 8 to 32 bits is therefore exercised through the width field. Random data is drawn mostly from small values and all-ones, so that clamping, modulo wraps and full-width overflow happen often within a few thousand cycles. Directed sequences take each mode through its boundary before the random phase starts.

// File: rtl/evc_pkg.sv
package evc_pkg;
    typedef enum logic [1:0] {
        CM_FREE   = 2'd0,
        CM_SINGLE = 2'd1,
        CM_CLAMP  = 2'd2,
        CM_MODN   = 2'd3
    } cmode_t;

    typedef enum logic [1:0] {
        IX_NONE    = 2'd0,
        IX_LOAD    = 2'd1,
        IX_CLEAR   = 2'd2,
        IX_CAPTURE = 2'd3
    } ixact_t;

    typedef enum logic [2:0] {
        HC_NOP      = 3'd0,
        HC_LOAD     = 3'd1,
        HC_CLRCNT   = 3'd2,
        HC_CLRDATA  = 3'd3,
        HC_CAPTURE  = 3'd4,
        HC_CLRSTAT  = 3'd5
    } hcmd_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_STOP = 1'b1
    } run_t;

    localparam int EV_CARRY  = 0;
    localparam int EV_BORROW = 1;
    localparam int EV_MATCH  = 2;
    localparam int EV_INDEX  = 3;
    localparam int EV_N      = 4;

    localparam logic [1:0] HA_DATA  = 2'd0;
    localparam logic [1:0] HA_MODE0 = 2'd1;
    localparam logic [1:0] HA_MODE1 = 2'd2;
endpackage

// File: rtl/evc_step.sv
module evc_step
    import evc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] limit,
    input  cmode_t       mode,
    input  logic         up,
    output logic [W-1:0] nxt,
    output logic         carry,
    output logic         borrow
);
    logic [W-1:0] top;

    always_comb begin
        top    = (mode == CM_FREE || mode == CM_SINGLE) ? {W{1'b1}} : limit;
        nxt    = count;
        carry  = 1'b0;
        borrow = 1'b0;
        if (up) begin
            if (count >= top) begin
                carry = 1'b1;
                nxt   = (mode == CM_CLAMP) ? count : '0;
            end else begin
                nxt = count + 1'b1;
            end
        end else begin
            if (count == '0) begin
                borrow = 1'b1;
                unique case (mode)
                    CM_CLAMP: nxt = count;
                    CM_MODN:  nxt = limit;
                    default:  nxt = {W{1'b1}};
                endcase
            end else begin
                nxt = count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/evc_flag.sv
module evc_flag
    import evc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_N-1:0] ev_set,
    input  logic            clr,
    input  cmode_t          mode,
    input  logic [EV_N-1:0] ev_en,
    input  logic            carry_p,
    input  logic            borrow_p,
    input  logic            idx_p,
    input  logic            match,
    input  logic            dir_q,
    output logic [EV_N-1:0] status,
    output logic            flag_latched_n,
    output logic            flag_dyn_n
);
    logic [EV_N-1:0] live;
    logic            dyn_act;

    for (genvar i = 0; i < EV_N; i++) begin : g_stat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status[i] <= 1'b0;
            else        status[i] <= (status[i] & ~clr) | ev_set[i];
        end
    end

    always_comb begin
        live            = '0;
        live[EV_CARRY]  = carry_p;
        live[EV_BORROW] = borrow_p;
        live[EV_MATCH]  = match;
        live[EV_INDEX]  = idx_p;
        unique case (mode)
            CM_FREE:   dyn_act = |(live & ev_en);
            CM_SINGLE: dyn_act = carry_p | borrow_p;
            CM_CLAMP:  dyn_act = (match & dir_q) | borrow_p;
            CM_MODN:   dyn_act = (match & dir_q) | borrow_p;
        endcase
    end

    assign flag_latched_n = ~|(status & ev_en);
    assign flag_dyn_n     = ~dyn_act;
endmodule

// File: rtl/evt_counter.sv
module evt_counter
    import evc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cnt_strobe,
    input  logic            cnt_up,
    input  logic            count_enable,
    input  logic            idx_strobe,
    input  logic            host_wr,
    input  logic [1:0]      host_addr,
    input  logic [W-1:0]    host_wdata,
    input  logic [2:0]      host_cmd,
    output logic [W-1:0]    count_o,
    output logic [W-1:0]    hold_o,
    output logic [3:0]      status_o,
    output logic            flag_latched_n,
    output logic            flag_dyn_n
);
    localparam int M0_W = 6;

    function automatic logic [W-1:0] span_mask(input logic [1:0] code);
        return {W{1'b1}} >> (8 * int'(code));
    endfunction

    logic [W-1:0]    data_q, count_q, hold_q, limit, step_nxt, count_d;
    logic [M0_W-1:0] mode0_q;
    logic [EV_N-1:0] mode1_q, ev_set;
    logic            dir_q, carry_p, borrow_p, idx_p;
    logic            step_carry, step_borrow, match;
    logic            do_clear, do_load, do_cap, step_take;
    logic            carry_c, borrow_c, mode0_wr;
    cmode_t          mode;
    ixact_t          ixact;
    hcmd_t           cmd;
    run_t            st_q, st_d;

    assign mode     = cmode_t'(mode0_q[1:0]);
    assign ixact    = ixact_t'(mode0_q[3:2]);
    assign cmd      = hcmd_t'(host_cmd);
    assign limit    = data_q & span_mask(mode0_q[5:4]);
    assign match    = (count_q == limit);
    assign mode0_wr = host_wr && host_addr == HA_MODE0;

    evc_step #(.W(W)) u_step (
        .count  (count_q),
        .limit  (limit),
        .mode   (mode),
        .up     (cnt_up),
        .nxt    (step_nxt),
        .carry  (step_carry),
        .borrow (step_borrow)
    );

    // Run/stop state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // Next state and datapath decisions
    always_comb begin
        do_clear  = (cmd == HC_CLRCNT) || (idx_strobe && ixact == IX_CLEAR);
        do_load   = (cmd == HC_LOAD)   || (idx_strobe && ixact == IX_LOAD);
        do_cap    = (cmd == HC_CAPTURE) || (idx_strobe && ixact == IX_CAPTURE);
        step_take = cnt_strobe && count_enable && (st_q == ST_RUN)
                    && !do_clear && !do_load;
        carry_c   = step_take && step_carry;
        borrow_c  = step_take && step_borrow;
        if (do_clear)       count_d = '0;
        else if (do_load)   count_d = limit;
        else if (step_take) count_d = step_nxt;
        else                count_d = count_q;
        st_d = st_q;
        unique case (st_q)
            ST_RUN:  if (mode == CM_SINGLE && (carry_c || borrow_c) && !mode0_wr)
                         st_d = ST_STOP;
            ST_STOP: if (do_clear || do_load || mode0_wr)
                         st_d = ST_RUN;
        endcase
        ev_set            = '0;
        ev_set[EV_CARRY]  = carry_c;
        ev_set[EV_BORROW] = borrow_c;
        ev_set[EV_MATCH]  = match;
        ev_set[EV_INDEX]  = idx_strobe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            mode0_q  <= '0;
            mode1_q  <= '0;
            count_q  <= '0;
            hold_q   <= '0;
            dir_q    <= 1'b0;
            carry_p  <= 1'b0;
            borrow_p <= 1'b0;
            idx_p    <= 1'b0;
        end else begin
            if (cmd == HC_CLRDATA)                      data_q <= '0;
            else if (host_wr && host_addr == HA_DATA)   data_q <= host_wdata;
            if (mode0_wr)                               mode0_q <= host_wdata[M0_W-1:0];
            if (host_wr && host_addr == HA_MODE1)       mode1_q <= host_wdata[EV_N-1:0];
            count_q  <= count_d;
            if (do_cap)    hold_q <= count_q;
            if (step_take) dir_q  <= cnt_up;
            carry_p  <= carry_c;
            borrow_p <= borrow_c;
            idx_p    <= idx_strobe;
        end
    end

    evc_flag u_flag (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_set         (ev_set),
        .clr            (cmd == HC_CLRSTAT),
        .mode           (mode),
        .ev_en          (mode1_q),
        .carry_p        (carry_p),
        .borrow_p       (borrow_p),
        .idx_p          (idx_p),
        .match          (match),
        .dir_q          (dir_q),
        .status         (status_o),
        .flag_latched_n (flag_latched_n),
        .flag_dyn_n     (flag_dyn_n)
    );

    assign count_o = count_q;
    assign hold_o  = hold_q;
endmodule

// File: rtl/evt_counter_chk.sv
module evt_counter_chk
    import evc_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_strobe,
    input logic         count_enable,
    input logic         idx_strobe,
    input logic [2:0]   host_cmd,
    input logic [W-1:0] count_o,
    input logic [3:0]   status_o,
    input logic         flag_latched_n,
    input logic         flag_dyn_n,
    input run_t         st_q,
    input logic [5:0]   mode0_q,
    input logic         carry_p,
    input logic         borrow_p,
    input logic         dir_q
);
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cnt_strobe && count_enable) && !idx_strobe && host_cmd == 3'd0)
        |=> $stable(count_o));

    a_r5_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP && !idx_strobe && host_cmd != 3'd1 && host_cmd != 3'd2)
        |=> $stable(count_o));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cmd != 3'd5)
        |=> ((status_o & $past(status_o)) == $past(status_o)));

    a_r10_latched_src: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_latched_n |-> (status_o != 4'd0));

    a_r2_carry_up: assert property (@(posedge clk) disable iff (!rst_n)
        carry_p |-> dir_q);

    a_r2_borrow_down: assert property (@(posedge clk) disable iff (!rst_n)
        borrow_p |-> !dir_q);

    a_r11_single_dyn: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0_q[1:0] == 2'd1 && !flag_dyn_n) |-> (carry_p || borrow_p));
endmodule

bind evt_counter evt_counter_chk #(.W(W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cnt_strobe     (cnt_strobe),
    .count_enable   (count_enable),
    .idx_strobe     (idx_strobe),
    .host_cmd       (host_cmd),
    .count_o        (count_o),
    .status_o       (status_o),
    .flag_latched_n (flag_latched_n),
    .flag_dyn_n     (flag_dyn_n),
    .st_q           (st_q),
    .mode0_q        (mode0_q),
    .carry_p        (carry_p),
    .borrow_p       (borrow_p),
    .dir_q          (dir_q)
);

// File: tb/sim_evt_counter.sv
`timescale 1ns/1ps
module sim_evt_counter;
    localparam int W = 32;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic         cnt_strobe = 0, cnt_up = 0, count_enable = 1, idx_strobe = 0, host_wr = 0;
    logic [1:0]   host_addr = 0;
    logic [W-1:0] host_wdata = 0;
    logic [2:0]   host_cmd = 0;
    logic [W-1:0] count_o, hold_o;
    logic [3:0]   status_o;
    logic         flag_latched_n, flag_dyn_n;

    evt_counter #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_strobe(cnt_strobe), .cnt_up(cnt_up),
        .count_enable(count_enable), .idx_strobe(idx_strobe), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_cmd(host_cmd),
        .count_o(count_o), .hold_o(hold_o), .status_o(status_o),
        .flag_latched_n(flag_latched_n), .flag_dyn_n(flag_dyn_n)
    );

    int checks = 0;
    int errors = 0;

    // reference state
    logic [W-1:0] m_data = 0, m_cnt = 0, m_hold = 0;
    logic [5:0]   m_m0 = 0;
    logic [3:0]   m_m1 = 0, m_stat = 0;
    logic         m_dir = 0, m_cp = 0, m_bp = 0, m_ip = 0, m_stop = 0;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] lim_of(input logic [W-1:0] d, input logic [1:0] k);
        return d & (ONES >> (8 * int'(k)));
    endfunction

    function automatic string req_of(input logic [1:0] md);
        case (md)
            2'd0: return "R2 free count";
            2'd1: return "R5 one-shot count";
            2'd2: return "R4 clamp count";
            default: return "R3 modulo count";
        endcase
    endfunction

    function automatic logic dyn_exp();
        logic [W-1:0] l;
        logic mt;
        l  = lim_of(m_data, m_m0[5:4]);
        mt = (m_cnt == l);
        case (m_m0[1:0])
            2'd0: return |(m_m1 & {m_ip, mt, m_bp, m_cp});
            2'd1: return m_cp | m_bp;
            default: return (mt & m_dir) | m_bp;
        endcase
    endfunction

    task automatic compare();
        chk(req_of(m_m0[1:0]), count_o, m_cnt);
        chk("R6 hold", hold_o, m_hold);
        chk("R9 status", {28'd0, status_o}, {28'd0, m_stat});
        chk("R10 latched flag", {31'd0, flag_latched_n}, {31'd0, ~|(m_stat & m_m1)});
        chk("R11 dynamic flag", {31'd0, flag_dyn_n}, {31'd0, ~dyn_exp()});
    endtask

    task automatic tick();
        logic [W-1:0] l, top, n;
        logic mt, clrc, ld, cap, take, c, b, m0w;
        l    = lim_of(m_data, m_m0[5:4]);
        mt   = (m_cnt == l);
        clrc = host_cmd == 3'd2 || (idx_strobe && m_m0[3:2] == 2'd2);
        ld   = host_cmd == 3'd1 || (idx_strobe && m_m0[3:2] == 2'd1);
        cap  = host_cmd == 3'd4 || (idx_strobe && m_m0[3:2] == 2'd3);
        take = cnt_strobe && count_enable && !m_stop && !clrc && !ld;
        m0w  = host_wr && host_addr == 2'd1;
        top  = (m_m0[1:0] < 2) ? ONES : l;
        c = 0; b = 0; n = m_cnt;
        if (cnt_up) begin
            if (m_cnt >= top) begin c = 1; n = (m_m0[1:0] == 2) ? m_cnt : '0; end
            else n = m_cnt + 1;
        end else begin
            if (m_cnt == 0) begin
                b = 1;
                n = (m_m0[1:0] == 2) ? m_cnt : (m_m0[1:0] == 3) ? l : ONES;
            end else n = m_cnt - 1;
        end
        c = c & take; b = b & take;
        m_stat = ((host_cmd == 3'd5) ? 4'd0 : m_stat) | {idx_strobe, mt, b, c};
        if (m_stop) begin
            if (clrc || ld || m0w) m_stop = 0;
        end else if (m_m0[1:0] == 2'd1 && (c || b) && !m0w) m_stop = 1;
        if (cap) m_hold = m_cnt;
        if (clrc) m_cnt = 0; else if (ld) m_cnt = l; else if (take) m_cnt = n;
        if (take) m_dir = cnt_up;
        m_cp = c; m_bp = b; m_ip = idx_strobe;
        if (host_cmd == 3'd3) m_data = 0;
        else if (host_wr && host_addr == 2'd0) m_data = host_wdata;
        if (m0w) m_m0 = host_wdata[5:0];
        if (host_wr && host_addr == 2'd2) m_m1 = host_wdata[3:0];
        @(posedge clk);
        @(negedge clk);
        compare();
        cnt_strobe = 0; idx_strobe = 0; host_wr = 0; host_cmd = 0;
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [W-1:0] v);
        host_wr = 1; host_addr = a; host_wdata = v; tick();
    endtask
    task automatic hcmd(input logic [2:0] c);
        host_cmd = c; tick();
    endtask
    task automatic cstep(input logic up);
        cnt_strobe = 1; cnt_up = up; tick();
    endtask
    task automatic pulse_idx();
        idx_strobe = 1; tick();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 count", count_o, '0);
        chk("R1 hold", hold_o, '0);
        chk("R1 status", {28'd0, status_o}, '0);
        chk("R1 flags", {30'd0, flag_latched_n, flag_dyn_n}, 32'd3);
        rst_n = 1;
        tick();

        // R8 width mask, R6 load
        hwrite(2'd0, 32'h1234_5678);
        hwrite(2'd1, 32'h30);
        hcmd(3'd1);
        chk("R8 8-bit limit load", count_o, 32'h78);
        hwrite(2'd1, 32'h10);
        hcmd(3'd1);
        chk("R8 24-bit limit load", count_o, 32'h34_5678);

        // R12 enable low
        count_enable = 0;
        repeat (3) cstep(1'b1);
        chk("R12 gated strobe", count_o, 32'h34_5678);
        count_enable = 1;

        // R2 free wrap, R10 latched flag
        hwrite(2'd1, 32'h0);
        hwrite(2'd2, 32'h1);
        hwrite(2'd0, ONES);
        hcmd(3'd1);
        cstep(1'b1);
        chk("R2 overflow to zero", count_o, '0);
        chk("R10 latched low on carry", {31'd0, flag_latched_n}, '0);
        cstep(1'b0);
        chk("R2 underflow to ones", count_o, ONES);
        hcmd(3'd5);
        chk("R9 carry bit cleared", {31'd0, status_o[0]}, '0);
        chk("R10 latched released", {31'd0, flag_latched_n}, 32'd1);

        // R3 modulo
        hwrite(2'd1, 32'h3);
        hwrite(2'd0, 32'd3);
        hcmd(3'd2);
        repeat (3) cstep(1'b1);
        chk("R11 match while up", {31'd0, flag_dyn_n}, '0);
        cstep(1'b1);
        chk("R3 wrap up", count_o, '0);
        cstep(1'b0);
        chk("R3 wrap down", count_o, 32'd3);

        // R4 clamp
        hwrite(2'd1, 32'h2);
        hwrite(2'd0, 32'd2);
        hcmd(3'd2);
        repeat (4) cstep(1'b1);
        chk("R4 top clamp", count_o, 32'd2);
        repeat (3) cstep(1'b0);
        chk("R4 bottom clamp", count_o, '0);

        // R5 one-shot
        hwrite(2'd1, 32'h1);
        hcmd(3'd2);
        cstep(1'b0);
        chk("R5 wrap before stop", count_o, ONES);
        cstep(1'b0);
        chk("R5 stopped", count_o, ONES);
        hcmd(3'd2);
        cstep(1'b1);
        chk("R5 resumed", count_o, 32'd1);

        // R7 index actions
        hwrite(2'd1, 32'h04);
        hwrite(2'd0, 32'd9);
        pulse_idx();
        chk("R7 index load", count_o, 32'd9);
        hwrite(2'd1, 32'h0C);
        cstep(1'b1);
        pulse_idx();
        chk("R7 index capture", hold_o, 32'd10);
        hwrite(2'd1, 32'h08);
        pulse_idx();
        chk("R7 index clear", count_o, '0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            cnt_strobe   = ($urandom % 100) < 60;
            cnt_up       = $urandom % 2;
            count_enable = ($urandom % 100) < 90;
            idx_strobe   = ($urandom % 100) < 5;
            r = $urandom % 100;
            if (r < 5) begin
                host_wr   = 1;
                host_addr = 2'($urandom % 3);
                case ($urandom % 3)
                    0: host_wdata = W'($urandom % 13);
                    1: host_wdata = ONES - W'($urandom % 3);
                    default: host_wdata = W'($urandom);
                endcase
                if (host_addr != 2'd0) host_wdata = W'($urandom % 64);
            end
            if (($urandom % 100) < 6) host_cmd = 3'(1 + $urandom % 5);
            tick();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule